// File: doc/BRIEF.md
# Posted Read Result Buffer with Resend

This block sits between a debugger-facing request port and an access port, which is the target-side engine that performs reads. Reads are posted. An access-port read request hands back the result of the previous access-port read and launches a new access. A buffer-read request hands back the pending result and launches nothing. A resend request repeats the value most recently delivered, so the debugger can recover data lost on a corrupted transfer without touching the target again.

While an access is outstanding, the block raises a stall output and accepts no request. The response channel is forwarded straight into the delivery path, so a request presented in the same cycle as the response sees the new data. A read-OK flag records whether the latest result was good.

The controller has two states, IDLE and BUSY, and three named transitions:
- ISSUE goes from IDLE to BUSY when an access-port read is accepted.
- COMPLETE goes from BUSY to IDLE when the response arrives and no new access-port read is accepted in that cycle.
- CHAIN goes from BUSY back to BUSY when the response arrives and a new access-port read is accepted in the same cycle.

Top module: `rrb_top`

## Requirements
- R1: After reset, `stall`, `rd_valid`, `read_ok` and `ap_req` are 0, and `rd_data` is all zeros.
- R2: `req_kind` is coded as follows: 0 is an access-port read, 1 is a buffer read, 2 is a resend and 3 is reserved. A request is accepted in a cycle where `req_valid` is 1 and `stall` is 0. For codes 0 to 2, `rd_valid` pulses high for exactly one cycle, in the cycle after acceptance. Code 3 produces no `rd_valid`, no `ap_req` and no state change.
- R3: An accepted access-port read delivers the buffered result on `rd_data`. It raises `ap_req` for one cycle in the cycle after acceptance. No other kind ever raises `ap_req`.
- R4: An accepted buffer read delivers the buffered result without raising `ap_req`. After any buffer read or access-port read, the buffer is invalid until the next access-port response is taken.
- R5: When an access-port read or a buffer read is accepted while the buffer is invalid, the delivered data is zero and the resend value is left unchanged.
- R6: `stall` is high from the cycle after an access-port read is accepted. It stays high until the cycle in which `ap_rsp_valid` is 1, and in that cycle it is low. No request of any kind is accepted while `stall` is high.
- R7: A request accepted in the cycle in which the response arrives delivers that response's data.
- R8: A resend delivers the value of the last valid delivery made by an access-port read or a buffer read, or zero if there has been none since reset. Repeated resends return the same value.
- R9: When a response is taken, `read_ok` takes the value of `ap_rsp_ok`. A buffer read of an invalid buffer clears `read_ok`. No other event changes `read_ok`.
- R10: `ap_rsp_valid` is ignored while no access is outstanding. Such a response does not change the buffer, the resend value or `read_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request code (see R2) |
| stall | output | 1 | Requests held off while an access is outstanding |
| rd_valid | output | 1 | One-cycle pulse marking delivered data |
| rd_data | output | DATA_W | Delivered data |
| read_ok | output | 1 | Status of the latest result |
| ap_req | output | 1 | One-cycle pulse starting an access-port read |
| ap_rsp_valid | input | 1 | Access-port response present |
| ap_rsp_ok | input | 1 | Response status is good |
| ap_rsp_data | input | DATA_W | Response data |

## Verification
The bench builds the block with `DATA_W` set to 16, so the random response words cover the full data path and a zero delivered by mistake is unlikely to pass unnoticed. The access-port model answers between one and three cycles after each request. Because the response delay is that short, the bench reaches both CHAIN and the forwarding case of R7 many times. It also injects stray responses while the block is IDLE to exercise R10.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    typedef enum logic [1:0] {
        KIND_AP  = 2'd0,
        KIND_BUF = 2'd1,
        KIND_RSD = 2'd2,
        KIND_RSV = 2'd3
    } req_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rrb_seq.sv
module rrb_seq
    import rrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       ap_rsp_valid,
    output logic       stall,
    output logic       take_ap,
    output logic       take_buf,
    output logic       take_rsd,
    output logic       rsp_take,
    output logic       ap_req
);

    seq_state_e state_q, state_d;
    logic       go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ap_req  <= 1'b0;
        end else begin
            state_q <= state_d;
            ap_req  <= take_ap;
        end
    end

    // outputs and next state
    always_comb begin
        stall    = (state_q == ST_BUSY) && !ap_rsp_valid;
        rsp_take = (state_q == ST_BUSY) && ap_rsp_valid;
        go       = req_valid && !stall;
        take_ap  = go && (req_kind == KIND_AP);
        take_buf = go && (req_kind == KIND_BUF);
        take_rsd = go && (req_kind == KIND_RSD);
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: if (take_ap) state_d = ST_BUSY;           // ISSUE
            ST_BUSY: if (ap_rsp_valid)
                         state_d = take_ap ? ST_BUSY : ST_IDLE; // CHAIN / COMPLETE
            default: state_d = ST_IDLE;
        endcase
    end

    assert_ap_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall && req_kind == KIND_AP) |=> ap_req);

    assert_no_issue_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || stall || req_kind != KIND_AP) |=> !ap_req);

    assert_stall_after_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_req && !ap_rsp_valid) |-> stall);

    assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall && req_kind == KIND_RSV && !ap_rsp_valid) |=> $stable(state_q));

endmodule

// File: rtl/rrb_store.sv
module rrb_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_ap,
    input  logic              take_buf,
    input  logic              take_rsd,
    input  logic              rsp_take,
    input  logic              ap_rsp_ok,
    input  logic [DATA_W-1:0] ap_rsp_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              read_ok
);

    logic [DATA_W-1:0] buf_q, rsd_q, eff_data;
    logic              bval_q, eff_valid, drain;

    always_comb begin
        eff_valid = rsp_take || bval_q;
        eff_data  = rsp_take ? ap_rsp_data : buf_q;
        drain     = take_ap || take_buf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            bval_q   <= 1'b0;
            rsd_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            read_ok  <= 1'b0;
        end else begin
            rd_valid <= drain || take_rsd;
            if (rsp_take) begin
                buf_q   <= ap_rsp_data;
                bval_q  <= 1'b1;
                read_ok <= ap_rsp_ok;
            end
            if (drain) begin
                bval_q  <= 1'b0;
                rd_data <= eff_valid ? eff_data : '0;
                if (eff_valid) rsd_q <= eff_data;
                if (take_buf && !eff_valid) read_ok <= 1'b0;
            end else if (take_rsd) begin
                rd_data <= rsd_q;
            end
        end
    end

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drain || take_rsd) |=> rd_valid);

    assert_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain || take_rsd) |=> !rd_valid);

    assert_zero_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !eff_valid) |=> (rd_data == '0 && $stable(rsd_q)));

    assert_resend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_rsd |=> $stable(rsd_q));

    assert_ok_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |=> (read_ok == $past(ap_rsp_ok)));

endmodule

// File: rtl/rrb_top.sv
module rrb_top #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    output logic              stall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              read_ok,
    output logic              ap_req,
    input  logic              ap_rsp_valid,
    input  logic              ap_rsp_ok,
    input  logic [DATA_W-1:0] ap_rsp_data
);

    logic take_ap, take_buf, take_rsd, rsp_take;

    rrb_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .ap_rsp_valid (ap_rsp_valid),
        .stall        (stall),
        .take_ap      (take_ap),
        .take_buf     (take_buf),
        .take_rsd     (take_rsd),
        .rsp_take     (rsp_take),
        .ap_req       (ap_req)
    );

    rrb_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_ap     (take_ap),
        .take_buf    (take_buf),
        .take_rsd    (take_rsd),
        .rsp_take    (rsp_take),
        .ap_rsp_ok   (ap_rsp_ok),
        .ap_rsp_data (ap_rsp_data),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .read_ok     (read_ok)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !ap_req && !read_ok));

endmodule

// File: tb/rrb_top_bench.sv
`timescale 1ns/1ps
module rrb_top_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          stall, rd_valid, read_ok, ap_req;
    logic [DW-1:0] rd_data;
    logic          ap_rsp_valid = 1'b0;
    logic          ap_rsp_ok = 1'b0;
    logic [DW-1:0] ap_rsp_data = '0;

    always #4 clk = ~clk;

    rrb_top #(.DATA_W(DW)) u_rrb_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data), .read_ok(read_ok),
        .ap_req(ap_req), .ap_rsp_valid(ap_rsp_valid), .ap_rsp_ok(ap_rsp_ok),
        .ap_rsp_data(ap_rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_busy, m_bval, m_ok;
    logic [DW-1:0] m_buf, m_rsd;
    // access-port model state
    bit          ap_pend;
    int          ap_cnt;

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] deliver(input bit ev, input logic [DW-1:0] ed);
        return ev ? ed : '0;
    endfunction

    task automatic step(input bit rv, input logic [1:0] k, input bit stray);
        bit take, ev, estall, acc, ka, kb, kr, exp_rdv, fwd;
        logic [DW-1:0] ed, exp_data, old_rsd;
        bit old_ok;
        string dtag;
        @(negedge clk);
        ap_rsp_valid = 1'b0;
        if (ap_pend && ap_cnt == 0) begin
            ap_rsp_valid = 1'b1;
            ap_rsp_data  = DW'($urandom);
            ap_rsp_ok    = ($urandom % 4) != 0;
            ap_pend      = 1'b0;
        end else if (ap_pend) begin
            ap_cnt--;
        end else if (stray) begin
            ap_rsp_valid = 1'b1;
            ap_rsp_data  = DW'($urandom);
            ap_rsp_ok    = ~m_ok;
        end
        req_valid = rv;
        req_kind  = k;
        #1;
        take   = m_busy && ap_rsp_valid;
        ev     = take || m_bval;
        ed     = take ? ap_rsp_data : m_buf;
        estall = m_busy && !ap_rsp_valid;
        chk(stall == estall, "R6 stall", stall, estall);
        acc = rv && !estall;
        ka = acc && k == 2'd0;
        kb = acc && k == 2'd1;
        kr = acc && k == 2'd2;
        exp_rdv  = ka || kb || kr;
        exp_data = kr ? m_rsd : deliver(ev, ed);
        fwd      = take && (ka || kb);
        if (kr) dtag = "R8 resend data";
        else if (fwd) dtag = "R7 forwarded data";
        else if (!ev) dtag = "R5 invalid gives zero";
        else if (ka) dtag = "R3 posted data";
        else dtag = "R4 buffer data";
        old_rsd = m_rsd;
        old_ok  = m_ok;
        if (take) begin m_buf = ap_rsp_data; m_bval = 1'b1; m_ok = ap_rsp_ok; end
        if (ka || kb) begin
            if (ev) m_rsd = ed;
            m_bval = 1'b0;
            if (kb && !ev) m_ok = 1'b0;
        end
        if (ka) m_busy = 1'b1;
        else if (take) m_busy = 1'b0;
        @(posedge clk);
        #1;
        chk(rd_valid == exp_rdv, (acc && k == 2'd3) ? "R2 reserved no pulse" : "R2 pulse", rd_valid, exp_rdv);
        if (exp_rdv) chk(rd_data == exp_data, dtag, rd_data, exp_data);
        chk(ap_req == ka, "R3 ap_req", ap_req, ka);
        chk(read_ok == m_ok, (stray && !take && !acc) ? "R10 stray ignored" : "R9 read_ok", read_ok, m_ok);
        if ((ka || kb) && !ev) chk(m_rsd == old_rsd, "R5 resend kept", m_rsd, old_rsd);
        if (stray && !take && !acc) chk(read_ok == old_ok, "R10 stray ok", read_ok, old_ok);
        if (ap_req) begin ap_pend = 1'b1; ap_cnt = $urandom % 3; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_busy = 0; m_bval = 0; m_ok = 0; m_buf = '0; m_rsd = '0;
        ap_pend = 0; ap_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(stall == 1'b0 && rd_valid == 1'b0 && ap_req == 1'b0, "R1 reset ctrl", {stall, rd_valid, ap_req}, 0);
        chk(read_ok == 1'b0 && rd_data == '0, "R1 reset data", rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        step(1, 2'd1, 0);           // R5 buffer read while invalid
        step(1, 2'd2, 0);           // R8 resend after reset
        step(1, 2'd0, 0);           // R3 first posted read
        repeat (5) step(1, 2'd1, 0); // R6 held off, then drain
        step(1, 2'd2, 0);           // R8 repeat
        step(1, 2'd2, 0);
        step(1, 2'd1, 0);           // R5 invalid again
        step(0, 2'd0, 1);           // R10 stray response
        step(1, 2'd3, 0);           // R2 reserved code
        step(1, 2'd0, 0);
        repeat (6) step(1, 2'd0, 0); // R7 chained posted reads
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom), ($urandom % 8) == 0);
        end
        repeat (4) step(0, 2'd0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule